// File: doc/BRIEF.md
# Ethernet Transmit Abort Monitor

This block runs beside the transmit side of an Ethernet MAC and decides when the current transmit attempt must be given up. It tracks three things. The first is how long the attempt has waited for the medium, measured in bit-time ticks. The second is how many slot-length collision windows have passed since the current transmission began. The third is how many bytes have been sent. It also watches the collision line and a signal that means the transmit FIFO has run dry while frame data is still owed.

Each attempt can report at most one abort cause. When an abort is found, the monitor raises a one-cycle abort pulse. It also sets a sticky status flag naming the cause: late collision, excessive defer, oversize or underrun. Software clears the status flags with a single clear strobe. The collision-window limit, the maximum frame length and a huge-frame bypass are run-time inputs. The defer limit and the slot length are elaboration parameters, with defaults of 24288 and 512 bit times.

Top module: `tx_abort_mon`

## Requirements
- R1: A collision seen while `tx_on` is high aborts the attempt and sets `st_late`, but only when the number of completed collision windows is greater than `colwin_limit`. A collision when the count is at or below the limit has no effect. One window completes after every SLOT_BITS bit ticks with `tx_on` high.
- R2: The defer count starts at zero and advances once per `bit_tick` while `tx_req` is high and `tx_on` is low. If the DEFER_LIMIT-th tick arrives, the attempt is aborted and `st_defer` is set. The count freezes once `tx_on` rises and returns to zero when `tx_req` falls.
- R3: Bytes up to and including `max_len` are sent without effect. If `byte_sent` arrives while the frame's byte count already equals or exceeds `max_len`, the attempt is aborted and `st_oversize` is set.
- R4: While `huge_en` is 1, the byte count never causes an abort and `st_oversize` never rises.
- R5: If `fifo_starved` is high while `tx_on` is high, the attempt is aborted and `st_underrun` is set.
- R6: `abort` is high for exactly the one cycle after the cycle in which the cause was sampled. That same edge sets the cause's status flag.
- R7: Status flags stay set until `clr` is sampled high, which zeroes all four. If a new cause is sampled in the same cycle as `clr`, its flag ends up set.
- R8: After an abort, no further cause is recorded and no further abort is raised until `tx_req` has been sampled low. No abort follows a cycle in which `tx_req` is low.
- R9: When several causes are found in the same cycle, only one is recorded. The order of precedence is late collision, then underrun, then oversize.
- R10: After reset, `abort` and all four status flags are 0.
- R11: The collision-window and byte counts restart from zero whenever `tx_on` is low. A new transmission therefore starts with a fresh window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_req | input | 1 | Transmit attempt in progress (deferring or sending) |
| tx_on | input | 1 | Transmission has actually started on the medium |
| col | input | 1 | Collision detected |
| byte_sent | input | 1 | One byte of the frame left the MAC |
| fifo_starved | input | 1 | Transmit FIFO empty while frame data is still due |
| colwin_limit | input | WIN_W | Windows allowed before a collision counts as late |
| max_len | input | LEN_W | Maximum frame length in bytes |
| huge_en | input | 1 | Disables the maximum-length check |
| clr | input | 1 | Clears all status flags |
| abort | output | 1 | One-cycle abort pulse |
| st_late | output | 1 | Sticky late-collision flag |
| st_defer | output | 1 | Sticky excessive-defer flag |
| st_oversize | output | 1 | Sticky oversize flag |
| st_underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with DEFER_LIMIT=40, SLOT_BITS=8, WIN_W=4 and LEN_W=8, and toggles the bit tick every other clock. With these values a defer abort takes 80 cycles instead of tens of thousands. Three collision windows pass in 48 cycles, so late and early collisions, window restarts and the exact defer boundary all fit in short directed runs. An 8-bit length lets frames of 20 and 21 bytes probe the oversize edge, with and without the bypass.

// File: rtl/tam_pkg.sv
package tam_pkg;

    typedef struct packed {
        logic late;
        logic defer;
        logic oversize;
        logic underrun;
    } tam_status_t;

    typedef struct packed {
        tam_status_t status;
        logic        abort;
        logic        aborted;
    } tam_state_t;

endpackage

// File: rtl/tam_defer_timer.sv
module tam_defer_timer #(
    parameter int LIMIT = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    input  logic started,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             counting;

    always_comb begin
        counting = req && !started && tick;
        expire   = counting && (cnt_q == CNT_W'(LIMIT - 1));
        cnt_d    = cnt_q;
        if (!req) begin
            cnt_d = '0;
        end else if (counting && cnt_q != CNT_W'(LIMIT)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tam_slot_counter.sv
module tam_slot_counter #(
    parameter int SLOT_BITS = 512,
    parameter int WIN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    output logic [WIN_W-1:0] windows
);
    localparam int PH_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic [PH_W-1:0]  ph_d, ph_q;
    logic [WIN_W-1:0] win_d, win_q;

    always_comb begin
        ph_d  = ph_q;
        win_d = win_q;
        if (!active) begin
            ph_d  = '0;
            win_d = '0;
        end else if (tick) begin
            if (ph_q == PH_W'(SLOT_BITS - 1)) begin
                ph_d = '0;
                if (win_q != '1) win_d = win_q + WIN_W'(1);
            end else begin
                ph_d = ph_q + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            win_q <= '0;
        end else begin
            ph_q  <= ph_d;
            win_q <= win_d;
        end
    end

    assign windows = win_q;
endmodule

// File: rtl/tam_byte_counter.sv
module tam_byte_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             byte_sent,
    output logic [LEN_W-1:0] count
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active)                         cnt_d = '0;
        else if (byte_sent && cnt_q != '1)   cnt_d = cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/tx_abort_mon.sv
module tx_abort_mon
    import tam_pkg::*;
#(
    parameter int DEFER_LIMIT = 24288,
    parameter int SLOT_BITS   = 512,
    parameter int WIN_W       = 8,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_req,
    input  logic             tx_on,
    input  logic             col,
    input  logic             byte_sent,
    input  logic             fifo_starved,
    input  logic [WIN_W-1:0] colwin_limit,
    input  logic [LEN_W-1:0] max_len,
    input  logic             huge_en,
    input  logic             clr,
    output logic             abort,
    output logic             st_late,
    output logic             st_defer,
    output logic             st_oversize,
    output logic             st_underrun
);
    tam_state_t       s_d, s_q;
    tam_status_t      set_v;
    logic             defer_expire;
    logic [WIN_W-1:0] windows;
    logic [LEN_W-1:0] bytes;
    logic             armed, c_late, c_undr, c_ovsz, c_defer;

    tam_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .req(tx_req),
        .started(tx_on), .expire(defer_expire)
    );

    tam_slot_counter #(.SLOT_BITS(SLOT_BITS), .WIN_W(WIN_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .active(tx_on),
        .windows(windows)
    );

    tam_byte_counter #(.LEN_W(LEN_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .active(tx_on), .byte_sent(byte_sent),
        .count(bytes)
    );

    always_comb begin
        armed   = tx_req && !s_q.aborted;
        c_late  = armed && tx_on && col && (windows > colwin_limit);
        c_undr  = armed && tx_on && fifo_starved;
        c_ovsz  = armed && tx_on && byte_sent && !huge_en && (bytes >= max_len);
        c_defer = armed && defer_expire;

        set_v          = '0;
        set_v.late     = c_late;
        set_v.underrun = !c_late && c_undr;
        set_v.oversize = !c_late && !c_undr && c_ovsz;
        set_v.defer    = !c_late && !c_undr && !c_ovsz && c_defer;

        s_d         = s_q;
        s_d.abort   = |set_v;
        s_d.aborted = tx_req && (s_q.aborted || s_d.abort);
        if (clr) s_d.status = '0;
        s_d.status = s_d.status | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign abort       = s_q.abort;
    assign st_late     = s_q.status.late;
    assign st_defer    = s_q.status.defer;
    assign st_oversize = s_q.status.oversize;
    assign st_underrun = s_q.status.underrun;
endmodule

// File: rtl/tam_checker.sv
module tam_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic huge_en,
    input logic clr,
    input logic abort,
    input logic st_late,
    input logic st_defer,
    input logic st_oversize,
    input logic st_underrun
);
    logic [3:0] st;
    assign st = {st_late, st_defer, st_oversize, st_underrun};

    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort); // R6
    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (st != 4'b0)); // R6
    AST_NEW_FLAG_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & ~$past(st)) != 4'b0) |-> abort); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st & $past(st)) == $past(st))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !abort); // R8
    AST_ONE_NEW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st & ~$past(st))); // R9
    AST_HUGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_oversize) |-> !$past(huge_en)); // R4
endmodule

bind tx_abort_mon tam_checker u_tam_checker (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .huge_en(huge_en),
    .clr(clr), .abort(abort), .st_late(st_late), .st_defer(st_defer),
    .st_oversize(st_oversize), .st_underrun(st_underrun)
);

// File: tb/tx_abort_mon_bench.sv
module tx_abort_mon_bench;
    localparam int DEFER_LIM = 40;
    localparam int SLOT      = 8;
    localparam int WW        = 4;
    localparam int LW        = 8;
    localparam int WMAX      = (1 << WW) - 1;
    localparam int BMAX      = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic tx_req = 1'b0, tx_on = 1'b0, col = 1'b0, byte_sent = 1'b0;
    logic fifo_starved = 1'b0, huge_en = 1'b0, clr = 1'b0;
    logic [WW-1:0] colwin_limit = 4'd2;
    logic [LW-1:0] max_len = 8'd20;
    logic abort, st_late, st_defer, st_oversize, st_underrun;

    int checks = 0, failures = 0, cycles = 0, aborts_seen = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_def = 0, m_ph = 0, m_win = 0, m_bytes = 0;
    bit m_aborted = 0, m_abort = 0, m_late = 0, m_defer = 0, m_ovsz = 0, m_undr = 0;

    tx_abort_mon #(.DEFER_LIMIT(DEFER_LIM), .SLOT_BITS(SLOT), .WIN_W(WW), .LEN_W(LW))
    u_tx_abort_mon (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_req(tx_req),
        .tx_on(tx_on), .col(col), .byte_sent(byte_sent),
        .fifo_starved(fifo_starved), .colwin_limit(colwin_limit),
        .max_len(max_len), .huge_en(huge_en), .clr(clr), .abort(abort),
        .st_late(st_late), .st_defer(st_defer), .st_oversize(st_oversize),
        .st_underrun(st_underrun)
    );

    always #5 clk = ~clk;

    always @(negedge clk) bit_tick <= ~bit_tick;

    always @(posedge clk) begin
        bit armed, cl, cu, co, cd, sl, su, so, sd, any;
        if (!rst_n) begin
            m_def = 0; m_ph = 0; m_win = 0; m_bytes = 0;
            m_aborted = 0; m_abort = 0; m_late = 0; m_defer = 0; m_ovsz = 0; m_undr = 0;
        end else begin
            armed = tx_req && !m_aborted;
            cl = armed && tx_on && col && (m_win > int'(colwin_limit));
            cu = armed && tx_on && fifo_starved;
            co = armed && tx_on && byte_sent && !huge_en && (m_bytes >= int'(max_len));
            cd = armed && !tx_on && bit_tick && (m_def == DEFER_LIM - 1);
            sl = cl; su = !cl && cu; so = !cl && !cu && co; sd = !cl && !cu && !co && cd;
            any = sl || su || so || sd;
            if (!tx_req) m_def = 0;
            else if (!tx_on && bit_tick && m_def < DEFER_LIM) m_def++;
            if (!tx_on) begin m_ph = 0; m_win = 0; end
            else if (bit_tick) begin
                if (m_ph == SLOT - 1) begin m_ph = 0; if (m_win < WMAX) m_win++; end
                else m_ph++;
            end
            if (!tx_on) m_bytes = 0;
            else if (byte_sent && m_bytes < BMAX) m_bytes++;
            m_aborted = tx_req && (m_aborted || any);
            if (clr) begin m_late = 0; m_defer = 0; m_ovsz = 0; m_undr = 0; end
            m_late |= sl; m_defer |= sd; m_ovsz |= so; m_undr |= su;
            m_abort = any;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: got %b expected %b", tag, cycles, got, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        cycles++;
        if (abort === 1'b1) aborts_seen++;
        if (rst_n && !done) begin
            chk("R6 abort vs model", abort, m_abort);
            chk("R1 st_late vs model", st_late, m_late);
            chk("R2 st_defer vs model", st_defer, m_defer);
            chk("R3 st_oversize vs model", st_oversize, m_ovsz);
            chk("R5 st_underrun vs model", st_underrun, m_undr);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1; idle(1); clr = 1'b0;
    endtask

    task automatic end_frame();
        tx_on = 1'b0; tx_req = 1'b0; col = 1'b0; byte_sent = 1'b0;
        fifo_starved = 1'b0; idle(2);
    endtask

    task automatic send_bytes(input int n);
        byte_sent = 1'b1; idle(n); byte_sent = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int base;
        idle(3);
        chk("R10 reset abort", abort, 1'b0);
        chk("R10 reset flags", st_late | st_defer | st_oversize | st_underrun, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R2: excessive defer, single pulse
        base = aborts_seen;
        tx_req = 1'b1; idle(100);
        chk("R2 defer flag", st_defer, 1'b1);
        chk("R6 one pulse on defer", (aborts_seen - base) == 1, 1'b1);
        chk("R8 no second abort while deferring", abort, 1'b0);
        end_frame();
        pulse_clr(); idle(1);
        chk("R7 clear zeroes defer", st_defer, 1'b0);

        // R2: defer freezes once transmission starts; R3 oversize boundary
        tx_req = 1'b1; idle(30); tx_on = 1'b1; idle(100);
        chk("R2 no defer after start", st_defer, 1'b0);
        send_bytes(20); idle(2);
        chk("R3 max_len bytes allowed", st_oversize, 1'b0);
        send_bytes(1); idle(2);
        chk("R3 byte past max aborts", st_oversize, 1'b1);
        fifo_starved = 1'b1; idle(1); fifo_starved = 1'b0; idle(2);
        chk("R8 later underrun ignored", st_underrun, 1'b0);
        end_frame(); pulse_clr();

        // R4: huge frames bypass length check
        huge_en = 1'b1; tx_req = 1'b1; tx_on = 1'b1; idle(2);
        send_bytes(30); idle(2);
        chk("R4 huge frame no oversize", st_oversize, 1'b0);
        end_frame(); huge_en = 1'b0;

        // R1: early collision ignored, late collision aborts
        tx_req = 1'b1; tx_on = 1'b1; idle(20);
        col = 1'b1; idle(1); col = 1'b0; idle(2);
        chk("R1 early collision ignored", st_late, 1'b0);
        idle(40);
        col = 1'b1; idle(1); col = 1'b0; idle(2);
        chk("R1 late collision aborts", st_late, 1'b1);
        end_frame(); pulse_clr();

        // R11: restart of transmission restarts windows
        tx_req = 1'b1; tx_on = 1'b1; idle(60);
        tx_on = 1'b0; idle(2); tx_on = 1'b1; idle(2);
        col = 1'b1; idle(1); col = 1'b0; idle(2);
        chk("R11 windows restart", st_late, 1'b0);
        end_frame();

        // R5: underrun
        tx_req = 1'b1; tx_on = 1'b1; idle(4);
        fifo_starved = 1'b1; idle(1); fifo_starved = 1'b0; idle(2);
        chk("R5 underrun flag", st_underrun, 1'b1);
        end_frame(); pulse_clr();

        // R9: late collision beats underrun and oversize
        tx_req = 1'b1; tx_on = 1'b1; send_bytes(20); idle(40);
        col = 1'b1; fifo_starved = 1'b1; byte_sent = 1'b1; idle(1);
        col = 1'b0; fifo_starved = 1'b0; byte_sent = 1'b0; idle(2);
        chk("R9 late wins", st_late, 1'b1);
        chk("R9 underrun not recorded", st_underrun | st_oversize, 1'b0);
        end_frame(); pulse_clr();

        // R9: underrun beats oversize
        tx_req = 1'b1; tx_on = 1'b1; send_bytes(20);
        fifo_starved = 1'b1; byte_sent = 1'b1; idle(1);
        fifo_starved = 1'b0; byte_sent = 1'b0; idle(2);
        chk("R9 underrun wins", st_underrun, 1'b1);
        chk("R9 oversize not recorded", st_oversize, 1'b0);
        end_frame();

        // R7: set in the same cycle as clear survives
        tx_req = 1'b1; tx_on = 1'b1; send_bytes(20);
        byte_sent = 1'b1; clr = 1'b1; idle(1);
        byte_sent = 1'b0; clr = 1'b0; idle(2);
        chk("R7 set beats clear", st_oversize, 1'b1);
        chk("R7 old flag cleared", st_underrun, 1'b0);
        end_frame();

        finish_run();
    end

    initial begin
        while (cycles < 20000) @(negedge clk);
        failures++;
        $display("FAIL watchdog expired at cycle %0d: got running expected done", cycles);
        finish_run();
    end
endmodule